// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a small 8-bit controller core and its clock oscillator halt and when they start again. Software writes a power-control register. That register holds a light-sleep bit, which halts only the core, and a deep-sleep bit, which halts the core and the oscillator. It also holds a brown-out arm bit and a bit that lets the port drivers float. Once the arm bit is set, a falling edge on the power-fail detect input forces a brown-out stop. Only reset can end a brown-out stop.

Interrupt requests end a light or deep sleep. These include requests from timers that keep counting on an external clock while the oscillator is off. After a deep sleep, the controller keeps the core halted until the oscillator reports that it is ready. At every return to running, the controller gives one-cycle notice of how execution resumes: a restart from address zero after reset, a jump to an interrupt vector, or a continue at the next instruction. The oscillator, the interrupt priority logic and the core are outside this block. They are reached through plain level signals.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_ni` is low, and up to the first rising clock edge after it goes high, `resume_valid_o`=1 and `resume_kind_o`=0 (restart). In the same window `mode_o`=0 (run), `cpu_run_o`=1, `osc_en_o`=1 and `port_float_o`=0. On that first edge `resume_valid_o` drops to 0.
- R2: A write with `wr_data_i[0]`=1 (light sleep) moves `mode_o` to 1 on the second rising edge after the write is sampled. In mode 1, `cpu_run_o`=0 and `osc_en_o`=1, and `port_float_o` stays 0 even when the float bit `wr_data_i[3]` is 1.
- R3: A write with `wr_data_i[1]`=1 (deep sleep) moves `mode_o` to 2, with `cpu_run_o`=0 and `osc_en_o`=0. In mode 2, `port_float_o` equals the written float bit `wr_data_i[3]`.
- R4: When bits 0 and 1 are written as 1 together, deep sleep (mode 2) is entered, not light sleep.
- R5: A write with `wr_data_i[2]`=1 arms brown-out but changes no mode. While armed, a 1-to-0 change of `pwr_fail_ni` enters mode 3 on the second rising edge after the low level is first sampled. In mode 3, the core and oscillator are off and `port_float_o` equals the float bit. A falling edge while unarmed is ignored.
- R6: Mode 3 is left only through `rst_ni`. Interrupt requests do not change it.
- R7: In mode 1, any bit of `irq_i` high at a rising edge returns `mode_o` to 0 at that edge. `resume_valid_o` is then 1 for exactly one cycle.
- R8: In mode 2, any `irq_i` bit high moves to mode 4 (oscillator start-up). Mode 4 has `osc_en_o`=1 and `cpu_run_o`=0, and it holds until `osc_ready_i` is sampled high. Mode 0 and the one-cycle resume notice follow on that edge.
- R9: The resume kind after an interrupt wake is 1 (vector) when `irq_i & irq_en_i` is non-zero at the wake edge. Otherwise it is 2 (continue at the next instruction).
- R10: The sleep bits clear when a sleep is left, so after a resume the block stays in mode 0 without a new write.
- R11: An interrupt request already high before sleep is entered ends the sleep at the first edge after entry.
- R12: An armed power-fail edge that arrives during light sleep still enters mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset; ends every mode |
| wr_en_i | input | 1 | Power-control register write strobe; accepted only in run mode |
| wr_data_i | input | 4 | Register data: bit0 light sleep, bit1 deep sleep, bit2 brown-out arm, bit3 port float |
| pwr_fail_ni | input | 1 | Power-fail detect, low means failing |
| irq_i | input | NUM_IRQ | Interrupt requests (external, timer, serial) |
| irq_en_i | input | NUM_IRQ | Interrupt enables; select vector or continue resume |
| osc_ready_i | input | 1 | Oscillator running and stable |
| cpu_run_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| port_float_o | output | 1 | Tri-state the port drivers |
| mode_o | output | 3 | 0 run, 1 light sleep, 2 deep sleep, 3 brown-out, 4 oscillator start-up |
| resume_valid_o | output | 1 | One-cycle notice of a return to run |
| resume_kind_o | output | 2 | 0 restart, 1 vector, 2 continue |

## Verification
The bench targets several corner cases, each paired with the fault it would expose.

- **Both sleep bits written together.** A design that ranks light sleep first would keep the oscillator running.
- **Interrupt already pending at entry.** A level-blind or edge-only wake would leave the core asleep forever.
- **Interrupt that is requested but not enabled.** A design that ignores the enables would report a vector jump when it should continue.
- **Power-fail edge while unarmed, or during light sleep.** A design that reads the arm bit wrongly would stop the oscillator spuriously or miss the brown-out.
- **Interrupts during brown-out.** A design that accepts them would restart the core on a dying supply.
- **Resume without clearing the sleep bits.** A design that keeps them set would drop straight back into sleep, which shows as a mode change in the cycle after resume.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_IDLE  = 3'd1,
    M_PD    = 3'd2,
    M_HPD   = 3'd3,
    M_OSCW  = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    RK_RESTART  = 2'd0,
    RK_VECTOR   = 2'd1,
    RK_CONTINUE = 2'd2
  } resume_e;

  localparam int PCR_W = 4;

  // bit order is the software-visible layout
  typedef struct packed {
    logic flt;
    logic hpd;
    logic pd;
    logic idle;
  } pcr_t;
endpackage

// File: rtl/lpm_pcr.sv
module lpm_pcr
  import lpm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  pcr_t wr_data_i,
  input  logic clr_sleep_i,
  output pcr_t pcr_o
);
  pcr_t pcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcr_q <= '0;
    end else if (wr_en_i) begin
      pcr_q <= wr_data_i;
    end else if (clr_sleep_i) begin
      pcr_q.idle <= 1'b0;
      pcr_q.pd   <= 1'b0;
    end
  end

  assign pcr_o = pcr_q;
endmodule

// File: rtl/lpm_fall_det.sv
module lpm_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  // reset low so a high input after reset never looks like a fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  if (STAGES == 1) begin : g_one
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sync_q[0];
    end
    assign fall_o = prev_q & ~sync_q[0];
  end else begin : g_many
    assign fall_o = sync_q[LAST] & ~sync_q[LAST-1];
  end
endmodule

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 6
) (
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic               wake_o,
  output resume_e            kind_o
);
  assign wake_o = |irq_i;
  assign kind_o = (|(irq_i & irq_en_i)) ? RK_VECTOR : RK_CONTINUE;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ  = 6,
  parameter int PFD_SYNC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PCR_W-1:0]   wr_data_i,
  input  logic               pwr_fail_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               osc_ready_i,
  output logic               cpu_run_o,
  output logic               osc_en_o,
  output logic               port_float_o,
  output logic [2:0]         mode_o,
  output logic               resume_valid_o,
  output logic [1:0]         resume_kind_o
);
  mode_e   st_q, st_d;
  pcr_t    pcr;
  logic    pf_fall, wake, clr_sleep, wr_ok, sleeping;
  resume_e wake_kind, kind_q;
  logic    valid_q;

  assign wr_ok    = wr_en_i && (st_q == M_RUN);
  assign sleeping = (st_q == M_IDLE) || (st_q == M_PD);

  lpm_pcr u_pcr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_ok),
    .wr_data_i   (pcr_t'(wr_data_i)),
    .clr_sleep_i (clr_sleep),
    .pcr_o       (pcr)
  );

  lpm_fall_det #(.STAGES(PFD_SYNC)) u_pfd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pwr_fail_ni),
    .fall_o (pf_fall)
  );

  lpm_wake_sel #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_i    (irq_i),
    .irq_en_i (irq_en_i),
    .wake_o   (wake),
    .kind_o   (wake_kind)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      M_RUN: begin
        if (pcr.pd)        st_d = M_PD;   // deep sleep outranks light sleep
        else if (pcr.idle) st_d = M_IDLE;
      end
      M_IDLE:  if (wake)        st_d = M_RUN;
      M_PD:    if (wake)        st_d = M_OSCW;
      M_OSCW:  if (osc_ready_i) st_d = M_RUN;
      M_HPD:   st_d = M_HPD;
      default: st_d = M_RUN;
    endcase
    if (pcr.hpd && pf_fall && st_q != M_HPD) st_d = M_HPD;
  end

  assign clr_sleep = sleeping && (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= M_RUN;
      valid_q <= 1'b1;
      kind_q  <= RK_RESTART;
    end else begin
      st_q    <= st_d;
      valid_q <= (st_d == M_RUN) && (st_q != M_RUN);
      if (sleeping && wake && st_d != M_HPD) kind_q <= wake_kind;
    end
  end

  assign cpu_run_o      = (st_q == M_RUN);
  assign osc_en_o       = (st_q == M_RUN) || (st_q == M_IDLE) || (st_q == M_OSCW);
  assign port_float_o   = pcr.flt && ((st_q == M_PD) || (st_q == M_HPD));
  assign mode_o         = st_q;
  assign resume_valid_o = valid_q;
  assign resume_kind_o  = kind_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_ready_i,
  input logic       cpu_run_o,
  input logic       osc_en_o,
  input logic       port_float_o,
  input logic [2:0] mode_o,
  input logic       resume_valid_o
);
  assert_idle_clock_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1) |-> (!cpu_run_o && osc_en_o && !port_float_o));

  assert_stop_all_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 || mode_o == 3'd3) |-> (!cpu_run_o && !osc_en_o));

  assert_float_only_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_float_o |-> (mode_o == 3'd2 || mode_o == 3'd3));

  assert_hpd_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |=> (mode_o == 3'd3));

  assert_osc_wait_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && !osc_ready_i) |=> (mode_o == 3'd4 || mode_o == 3'd3));

  assert_resume_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_valid_o |-> (cpu_run_o && mode_o == 3'd0));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .osc_ready_i    (osc_ready_i),
  .cpu_run_o      (cpu_run_o),
  .osc_en_o       (osc_en_o),
  .port_float_o   (port_float_o),
  .mode_o         (mode_o),
  .resume_valid_o (resume_valid_o)
);

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;
  localparam int NI = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [3:0]    wr_data_i = '0;
  logic          pwr_fail_ni = 1'b1;
  logic [NI-1:0] irq_i = '0;
  logic [NI-1:0] irq_en_i = '0;
  logic          osc_ready_i = 1'b0;
  logic          cpu_run_o, osc_en_o, port_float_o, resume_valid_o;
  logic [2:0]    mode_o;
  logic [1:0]    resume_kind_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lpm_ctrl #(.NUM_IRQ(NI), .PFD_SYNC(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .pwr_fail_ni(pwr_fail_ni), .irq_i(irq_i), .irq_en_i(irq_en_i),
    .osc_ready_i(osc_ready_i), .cpu_run_o(cpu_run_o), .osc_en_o(osc_en_o),
    .port_float_o(port_float_o), .mode_o(mode_o),
    .resume_valid_o(resume_valid_o), .resume_kind_o(resume_kind_o)
  );

  typedef struct packed {
    logic [3:0]    wdata;
    logic [NI-1:0] irq;
    logic [NI-1:0] en;
    logic [2:0]    mode;
    logic          flt;
    logic [1:0]    kind;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{4'b0001, 6'b000001, 6'b000001, 3'd1, 1'b0, 2'd1},
    '{4'b1001, 6'b000100, 6'b000000, 3'd1, 1'b0, 2'd2},
    '{4'b0010, 6'b100000, 6'b100000, 3'd2, 1'b0, 2'd1},
    '{4'b1010, 6'b010000, 6'b000000, 3'd2, 1'b1, 2'd2},
    '{4'b0011, 6'b001000, 6'b001000, 3'd2, 1'b0, 2'd1},
    '{4'b1011, 6'b000010, 6'b000001, 3'd2, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    cyc(1);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk("R1 mode in reset", 8'(mode_o), 8'd0);
    chk("R1 valid in reset", 8'(resume_valid_o), 8'd1);
    cyc(1);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state and restart notice
    chk("R1 valid", 8'(resume_valid_o), 8'd1);
    chk("R1 kind", 8'(resume_kind_o), 8'd0);
    chk("R1 cpu/osc/float", {5'd0, cpu_run_o, osc_en_o, port_float_o}, 8'b110);
    chk("R1 mode", 8'(mode_o), 8'd0);
    rst_ni = 1'b1;
    chk("R1 valid before first edge", 8'(resume_valid_o), 8'd1);
    cyc(1);
    chk("R1 valid drops", 8'(resume_valid_o), 8'd0);

    // R2 R3 R4 R7 R8 R9 R10: table walk
    foreach (TBL[k]) begin
      wr(TBL[k].wdata);
      cyc(1);
      chk("R2/R3/R4 mode", 8'(mode_o), 8'(TBL[k].mode));
      chk("R2/R3 float", 8'(port_float_o), 8'(TBL[k].flt));
      chk("R2/R3 osc", 8'(osc_en_o), (TBL[k].mode == 3'd1) ? 8'd1 : 8'd0);
      chk("R2/R3 cpu", 8'(cpu_run_o), 8'd0);
      irq_i = TBL[k].irq; irq_en_i = TBL[k].en;
      cyc(1);
      if (TBL[k].mode == 3'd2) begin
        chk("R8 osc start mode", 8'(mode_o), 8'd4);
        chk("R8 osc on cpu off", {6'd0, osc_en_o, cpu_run_o}, 8'b10);
        irq_i = '0;
        cyc(2);
        chk("R8 hold without ready", 8'(mode_o), 8'd4);
        osc_ready_i = 1'b1;
        cyc(1);
      end
      chk("R7 resume mode", 8'(mode_o), 8'd0);
      chk("R7 resume valid", 8'(resume_valid_o), 8'd1);
      chk("R9 kind", 8'(resume_kind_o), 8'(TBL[k].kind));
      irq_i = '0; osc_ready_i = 1'b0;
      cyc(2);
      chk("R7 pulse single", 8'(resume_valid_o), 8'd0);
      chk("R10 stays run", 8'(mode_o), 8'd0);
    end

    // R5: unarmed fall ignored
    pwr_fail_ni = 1'b0;
    cyc(4);
    chk("R5 unarmed ignored", 8'(mode_o), 8'd0);
    pwr_fail_ni = 1'b1;
    cyc(3);

    // R5: armed fall enters brown-out
    wr(4'b1100);
    cyc(2);
    chk("R5 arm alone no mode", 8'(mode_o), 8'd0);
    pwr_fail_ni = 1'b0;
    cyc(1);
    chk("R5 not yet", 8'(mode_o), 8'd0);
    cyc(1);
    chk("R5 entered", 8'(mode_o), 8'd3);
    chk("R5 outputs", {5'd0, cpu_run_o, osc_en_o, port_float_o}, 8'b001);

    // R6: interrupts ignored in brown-out
    irq_i = '1; irq_en_i = '1;
    cyc(4);
    chk("R6 irq ignored", 8'(mode_o), 8'd3);
    chk("R6 no resume", 8'(resume_valid_o), 8'd0);
    irq_i = '0; pwr_fail_ni = 1'b1;
    do_reset();
    chk("R6 reset exits", 8'(mode_o), 8'd0);
    chk("R6 restart kind", 8'(resume_kind_o), 8'd0);
    cyc(3);

    // R12: armed fall during light sleep
    wr(4'b0101);
    cyc(1);
    chk("R12 idle first", 8'(mode_o), 8'd1);
    pwr_fail_ni = 1'b0;
    cyc(2);
    chk("R12 brown-out from idle", 8'(mode_o), 8'd3);
    pwr_fail_ni = 1'b1;
    do_reset();
    cyc(3);

    // R11: interrupt pending before entry
    irq_i = 6'b000001; irq_en_i = 6'b000001;
    wr(4'b0001);
    cyc(1);
    chk("R11 entered idle", 8'(mode_o), 8'd1);
    cyc(1);
    chk("R11 woke next edge", 8'(mode_o), 8'd0);
    chk("R11 vector", 8'(resume_kind_o), 8'd1);
    irq_i = '0;
    cyc(2);
    chk("R10 no re-entry", 8'(mode_o), 8'd0);

    done = 1'b1;
    summary();
  end
endmodule